// File: doc/BRIEF.md
# Event-to-Channel Interrupt Controller

This block gathers 64 one-bit event lines and turns them into 10 prioritised interrupt lines for a small real-time core. Events 0 to 31 arrive from sources outside the subsystem and events 32 to 63 from sources inside it. Each event has an enable bit, a sticky pending bit and a 4-bit channel field. Software writes the channel field to place each event on one channel. Several events may share a channel, but an event sits on only one channel at a time.

A rising edge on an event sets its pending bit. A channel requests service when at least one of its events is pending, enabled and mapped to it. Channel 0 has the highest priority. When the core starts servicing a channel, software claims it, and the controller then masks that channel and every lower-priority channel. An end-of-interrupt write restores the previous level from a small stack, so interrupts nest. The controller also reports which single event is the most urgent.

Software reaches every control and status field through one register port. The port has a write strobe, an address and write data. Read data is returned combinationally for the address presented.

Top module: `evt_intc`

## Requirements
- R1: An event's pending bit sets one clock after a 0-to-1 transition on its input. A level held high does not set it again after software clears it.
- R2: Pending words are at addresses 6 and 7; event e is bit e%32 of word 6+e/32. Writing 1 to a bit clears that pending bit. If a rising edge arrives in the same cycle as the clear, the bit stays set.
- R3: Channel fields are at addresses 8 to 15. Event e uses bits 4*(e%8)+3 to 4*(e%8) of word 8+e/8. After reset every field reads 15. Any event whose field holds 10 to 15 never raises an interrupt, but its pending bit still latches.
- R4: Writing a new channel field for an event moves it entirely to the new channel. The old channel no longer sees the event.
- R5: Each bit of `chan_irq` is a register. A channel's bit rises in the cycle after its qualifying pending bit becomes set.
- R6: `top_evt` and `top_valid` give the most urgent asserted event. The lowest-numbered asserted channel wins first, then the lowest-numbered event within that channel. The same value reads at address 3 as bit 6 = valid and bits 5:0 = index.
- R7: Bit 0 at address 0 is the global enable, and it resets to 0. While it is clear, every channel output is 0, but pending bits keep latching.
- R8: Writing a channel number c to address 1 claims c only when c is strictly lower in number than the current level. After a claim, only channels numbered below c may assert. A claim that does not meet this condition is ignored. Reading address 1 returns the current level, which is 10 when idle.
- R9: Any write to address 2 restores the level in force before the latest accepted claim. A write to address 2 with nothing claimed is ignored.
- R10: Per-event enables are at addresses 4 and 5, using the same bit layout as pending, and they reset to 0. A pending bit whose enable is clear raises no interrupt until it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_evt | input | 32 | Events 0 to 31, from outside the subsystem |
| int_evt | input | 32 | Events 32 to 63, from inside the subsystem |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| chan_irq | output | 10 | One registered interrupt line per channel |
| top_evt | output | 6 | Index of the most urgent asserted event |
| top_valid | output | 1 | `top_evt` is meaningful |

## Verification
Some properties are checked by the assertions on every cycle: pending bits never drop without a clear, every detected edge lands in a pending bit, no output asserts while the global enable was clear or at or below the nesting level, each accepted claim lowers the level, and the reported top event belongs to the lowest asserted channel. Other behaviours can only be shown by the bench's scenarios. These are: a moved mapping, unmapped field values, enable gating that is released later, the order of lower-numbered events within a channel, the set-wins collision between an edge and a clear, ignored claims, and unwinding the nesting stack past empty. These scenarios run against a behavioural model that is compared on every clock.

// File: rtl/evt_intc_pkg.sv
package evt_intc_pkg;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_CTRL,
    RK_ACK,
    RK_EOI,
    RK_TOP,
    RK_ENA,
    RK_PEND,
    RK_MAP
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] word;
  } reg_acc_t;

endpackage

// File: rtl/evt_intc_pend.sv
module evt_intc_pend #(
  parameter int unsigned NUM_EVT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [NUM_EVT-1:0] clr_vec,
  output logic [NUM_EVT-1:0] evt_rise,
  output logic [NUM_EVT-1:0] pend_q
);

  logic [NUM_EVT-1:0] evt_q;

  assign evt_rise = evt_in & ~evt_q;

  // a fresh edge wins over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      pend_q <= '0;
    end else begin
      evt_q  <= evt_in;
      pend_q <= (pend_q & ~clr_vec) | evt_rise;
    end
  end

endmodule

// File: rtl/evt_intc_resolve.sv
module evt_intc_resolve #(
  parameter int unsigned NUM_EVT   = 64,
  parameter int unsigned NUM_CH    = 10,
  parameter int unsigned MAP_W     = 4,
  parameter int unsigned EVT_IDX_W = 6
) (
  input  logic [NUM_EVT-1:0]       qual,
  input  logic [NUM_EVT*MAP_W-1:0] map_flat,
  input  logic [NUM_CH-1:0]        allow,
  output logic [NUM_CH-1:0]        ch_req,
  output logic                     top_v,
  output logic [EVT_IDX_W-1:0]     top_idx
);

  function automatic logic [EVT_IDX_W-1:0] first_set(input logic [NUM_EVT-1:0] v);
    logic [EVT_IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (v[i]) r = EVT_IDX_W'(i);
    end
    return r;
  endfunction

  logic [NUM_CH-1:0]    ch_hit;
  logic [EVT_IDX_W-1:0] ch_win [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [NUM_EVT-1:0] hit_v;
    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
      assign hit_v[e] = qual[e] && (map_flat[e*MAP_W +: MAP_W] == MAP_W'(c));
    end
    assign ch_hit[c] = |hit_v;
    assign ch_win[c] = first_set(hit_v);
  end

  assign ch_req = ch_hit & allow;

  always_comb begin
    top_v   = 1'b0;
    top_idx = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (ch_req[c]) begin
        top_v   = 1'b1;
        top_idx = ch_win[c];
      end
    end
  end

endmodule

// File: rtl/evt_intc_nest.sv
module evt_intc_nest #(
  parameter int unsigned NUM_CH = 10,
  parameter int unsigned DEPTH  = 10,
  parameter int unsigned LVL_W  = 4,
  parameter int unsigned DEP_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic [LVL_W-1:0] cur_lvl,
  output logic [DEP_W-1:0] depth,
  output logic             push_ok,
  output logic [NUM_CH-1:0] lvl_allow
);

  localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(NUM_CH);

  logic [LVL_W-1:0] stk [DEPTH];

  assign push_ok = push && (push_lvl < cur_lvl) && (depth < DEP_W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_lvl <= LVL_IDLE;
      depth   <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= LVL_IDLE;
    end else if (push_ok) begin
      stk[depth] <= cur_lvl;
      cur_lvl    <= push_lvl;
      depth      <= depth + 1'b1;
    end else if (pop && depth != '0) begin
      cur_lvl <= stk[depth - 1'b1];
      depth   <= depth - 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_allow
    assign lvl_allow[c] = LVL_W'(c) < cur_lvl;
  end

endmodule

// File: rtl/evt_intc.sv
module evt_intc
  import evt_intc_pkg::*;
#(
  parameter int unsigned EXT_EVT    = 32,
  parameter int unsigned INT_EVT    = 32,
  parameter int unsigned NUM_CH     = 10,
  parameter int unsigned MAP_W      = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned NEST_DEPTH = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EXT_EVT-1:0]   ext_evt,
  input  logic [INT_EVT-1:0]   int_evt,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [NUM_CH-1:0]    chan_irq,
  output logic [$clog2(EXT_EVT+INT_EVT)-1:0] top_evt,
  output logic                 top_valid
);

  localparam int unsigned NUM_EVT      = EXT_EVT + INT_EVT;
  localparam int unsigned EVT_IDX_W    = $clog2(NUM_EVT);
  localparam int unsigned LVL_W        = $clog2(NUM_CH + 1);
  localparam int unsigned DEP_W        = $clog2(NEST_DEPTH + 1);
  localparam int unsigned EVT_WORDS    = NUM_EVT / DATA_W;
  localparam int unsigned MAP_PER_WORD = DATA_W / MAP_W;
  localparam int unsigned MAP_WORDS    = NUM_EVT / MAP_PER_WORD;
  localparam int unsigned A_CTRL       = 0;
  localparam int unsigned A_ACK        = 1;
  localparam int unsigned A_EOI        = 2;
  localparam int unsigned A_TOP        = 3;
  localparam int unsigned ENA_BASE     = 4;
  localparam int unsigned PEND_BASE    = ENA_BASE + EVT_WORDS;
  localparam int unsigned MAP_BASE     = PEND_BASE + EVT_WORDS;

  function automatic reg_acc_t decode(input logic [ADDR_W-1:0] a);
    reg_acc_t    r;
    int unsigned ai;
    ai     = int'(a);
    r.kind = RK_NONE;
    r.word = '0;
    if (ai == A_CTRL)      r.kind = RK_CTRL;
    else if (ai == A_ACK)  r.kind = RK_ACK;
    else if (ai == A_EOI)  r.kind = RK_EOI;
    else if (ai == A_TOP)  r.kind = RK_TOP;
    else if (ai >= ENA_BASE && ai < ENA_BASE + EVT_WORDS) begin
      r.kind = RK_ENA;
      r.word = 8'(ai - ENA_BASE);
    end else if (ai >= PEND_BASE && ai < PEND_BASE + EVT_WORDS) begin
      r.kind = RK_PEND;
      r.word = 8'(ai - PEND_BASE);
    end else if (ai >= MAP_BASE && ai < MAP_BASE + MAP_WORDS) begin
      r.kind = RK_MAP;
      r.word = 8'(ai - MAP_BASE);
    end
    return r;
  endfunction

  // named internal events, shared with the bound checker
  reg_acc_t                 acc;
  logic                     gen_en;
  logic [NUM_EVT-1:0]       evt_all;
  logic [NUM_EVT-1:0]       evt_rise;
  logic [NUM_EVT-1:0]       pend_q;
  logic [NUM_EVT-1:0]       clr_vec;
  logic [NUM_EVT-1:0]       ena_q;
  logic [NUM_EVT*MAP_W-1:0] map_q;
  logic [LVL_W-1:0]         cur_lvl;
  logic [DEP_W-1:0]         nest_depth;
  logic                     push_ok;
  logic [NUM_CH-1:0]        lvl_allow;
  logic [NUM_CH-1:0]        ch_req;
  logic                     top_v_d;
  logic [EVT_IDX_W-1:0]     top_idx_d;
  logic                     claim_wr;
  logic                     eoi_wr;

  assign acc      = decode(reg_addr);
  assign evt_all  = {int_evt, ext_evt};
  assign claim_wr = reg_wr && (acc.kind == RK_ACK);
  assign eoi_wr   = reg_wr && (acc.kind == RK_EOI);

  always_comb begin
    clr_vec = '0;
    if (reg_wr && acc.kind == RK_PEND) clr_vec[acc.word*DATA_W +: DATA_W] = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en <= 1'b0;
      ena_q  <= '0;
      map_q  <= '1;
    end else if (reg_wr) begin
      case (acc.kind)
        RK_CTRL: gen_en <= reg_wdata[0];
        RK_ENA:  ena_q[acc.word*DATA_W +: DATA_W] <= reg_wdata;
        RK_MAP:  map_q[acc.word*DATA_W +: DATA_W] <= reg_wdata;
        default: ;
      endcase
    end
  end

  evt_intc_pend #(.NUM_EVT(NUM_EVT)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_in   (evt_all),
    .clr_vec  (clr_vec),
    .evt_rise (evt_rise),
    .pend_q   (pend_q)
  );

  evt_intc_nest #(
    .NUM_CH (NUM_CH),
    .DEPTH  (NEST_DEPTH),
    .LVL_W  (LVL_W),
    .DEP_W  (DEP_W)
  ) u_nest (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (claim_wr),
    .push_lvl  (reg_wdata[LVL_W-1:0]),
    .pop       (eoi_wr),
    .cur_lvl   (cur_lvl),
    .depth     (nest_depth),
    .push_ok   (push_ok),
    .lvl_allow (lvl_allow)
  );

  evt_intc_resolve #(
    .NUM_EVT   (NUM_EVT),
    .NUM_CH    (NUM_CH),
    .MAP_W     (MAP_W),
    .EVT_IDX_W (EVT_IDX_W)
  ) u_res (
    .qual     (pend_q & ena_q),
    .map_flat (map_q),
    .allow    (gen_en ? lvl_allow : '0),
    .ch_req   (ch_req),
    .top_v    (top_v_d),
    .top_idx  (top_idx_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_irq  <= '0;
      top_valid <= 1'b0;
      top_evt   <= '0;
    end else begin
      chan_irq  <= ch_req;
      top_valid <= top_v_d;
      top_evt   <= top_idx_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (acc.kind)
      RK_CTRL: reg_rdata = DATA_W'(gen_en);
      RK_ACK:  reg_rdata = DATA_W'(cur_lvl);
      RK_TOP:  reg_rdata = DATA_W'({top_valid, top_evt});
      RK_ENA:  reg_rdata = ena_q[acc.word*DATA_W +: DATA_W];
      RK_PEND: reg_rdata = pend_q[acc.word*DATA_W +: DATA_W];
      RK_MAP:  reg_rdata = map_q[acc.word*DATA_W +: DATA_W];
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/evt_intc_chk.sv
module evt_intc_chk #(
  parameter int unsigned NUM_EVT    = 64,
  parameter int unsigned NUM_CH     = 10,
  parameter int unsigned MAP_W      = 4,
  parameter int unsigned LVL_W      = 4,
  parameter int unsigned DEP_W      = 4,
  parameter int unsigned NEST_DEPTH = 10,
  parameter int unsigned EVT_IDX_W  = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_EVT-1:0]       evt_rise,
  input logic [NUM_EVT-1:0]       pend_q,
  input logic [NUM_EVT-1:0]       clr_vec,
  input logic                     gen_en,
  input logic [LVL_W-1:0]         cur_lvl,
  input logic [DEP_W-1:0]         nest_depth,
  input logic                     push_ok,
  input logic [NUM_EVT*MAP_W-1:0] map_q,
  input logic [NUM_CH-1:0]        chan_irq,
  input logic [EVT_IDX_W-1:0]     top_evt,
  input logic                     top_valid
);

  logic                     seen;
  logic [LVL_W-1:0]         lvl_prev;
  logic [NUM_EVT*MAP_W-1:0] map_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      lvl_prev <= LVL_W'(NUM_CH);
      map_prev <= '1;
    end else begin
      seen     <= 1'b1;
      lvl_prev <= cur_lvl;
      map_prev <= map_q;
    end
  end

  function automatic logic [NUM_CH-1:0] above_mask(input logic [LVL_W-1:0] l);
    logic [NUM_CH-1:0] m;
    for (int c = 0; c < NUM_CH; c++) m[c] = (c < int'(l));
    return m;
  endfunction

  function automatic logic [MAP_W-1:0] low_chan(input logic [NUM_CH-1:0] v);
    logic [MAP_W-1:0] r;
    r = '1;
    for (int c = NUM_CH - 1; c >= 0; c--) if (v[c]) r = MAP_W'(c);
    return r;
  endfunction

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (($past(evt_rise) & ~pend_q) == '0)); // R1

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (($past(pend_q) & ~$past(clr_vec) & ~pend_q) == '0)); // R2

  AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(gen_en)) |-> (chan_irq == '0)); // R7

  AST_LEVEL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ((chan_irq & ~above_mask(lvl_prev)) == '0)); // R8

  AST_CLAIM_DEEPER: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(push_ok)) |-> (cur_lvl < lvl_prev)); // R8

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(nest_depth) <= NEST_DEPTH); // R9

  AST_TOP_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && top_valid) |-> (map_prev[top_evt*MAP_W +: MAP_W] == low_chan(chan_irq))); // R6

endmodule

bind evt_intc evt_intc_chk #(
  .NUM_EVT    (NUM_EVT),
  .NUM_CH     (NUM_CH),
  .MAP_W      (MAP_W),
  .LVL_W      (LVL_W),
  .DEP_W      (DEP_W),
  .NEST_DEPTH (NEST_DEPTH),
  .EVT_IDX_W  (EVT_IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_rise   (evt_rise),
  .pend_q     (pend_q),
  .clr_vec    (clr_vec),
  .gen_en     (gen_en),
  .cur_lvl    (cur_lvl),
  .nest_depth (nest_depth),
  .push_ok    (push_ok),
  .map_q      (map_q),
  .chan_irq   (chan_irq),
  .top_evt    (top_evt),
  .top_valid  (top_valid)
);

// File: tb/tb_evt_intc.sv
module tb_evt_intc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] evt = '0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [9:0]  chan_irq;
  logic [5:0]  top_evt;
  logic        top_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evt_intc dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_evt   (evt[31:0]),
    .int_evt   (evt[63:32]),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .chan_irq  (chan_irq),
    .top_evt   (top_evt),
    .top_valid (top_valid)
  );

  // behavioural reference
  bit   m_pend [64];
  bit   m_en   [64];
  bit   m_prev [64];
  int   m_map  [64];
  bit   m_gen;
  int   m_lvl;
  int   m_stk  [$];
  logic [9:0] m_irq;
  bit   m_tv;
  int   m_top;

  function automatic logic [31:0] model_read(input int a);
    logic [31:0] r;
    r = '0;
    if (a == 0) r[0] = m_gen;
    else if (a == 1) r = 32'(m_lvl);
    else if (a == 3) r = {25'd0, m_tv, 6'(m_top)};
    else if (a == 4 || a == 5) for (int k = 0; k < 32; k++) r[k] = m_en[(a-4)*32+k];
    else if (a == 6 || a == 7) for (int k = 0; k < 32; k++) r[k] = m_pend[(a-6)*32+k];
    else if (a >= 8 && a <= 15) for (int k = 0; k < 8; k++) r[4*k +: 4] = 4'(m_map[(a-8)*8+k]);
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < 64; e++) begin
        m_pend[e] = 0; m_en[e] = 0; m_prev[e] = 0; m_map[e] = 15;
      end
      m_gen = 0; m_lvl = 10; m_stk.delete();
      m_irq = '0; m_tv = 0; m_top = 0;
    end else begin
      logic [9:0] nirq;
      bit nv;
      int ntop;
      int a;
      nirq = '0; nv = 0; ntop = 0;
      if (m_gen) begin
        for (int c = 0; c < 10; c++) begin
          if (c < m_lvl) begin
            for (int e = 0; e < 64; e++) begin
              if (m_pend[e] && m_en[e] && m_map[e] == c) begin
                nirq[c] = 1'b1;
                if (!nv) begin nv = 1; ntop = e; end
              end
            end
          end
        end
      end
      m_irq = nirq; m_tv = nv; m_top = ntop;
      a = int'(reg_addr);
      for (int e = 0; e < 64; e++) begin
        bit rise;
        bit clr;
        rise = evt[e] && !m_prev[e];
        clr  = reg_wr && (a == 6 + e/32) && reg_wdata[e%32];
        m_pend[e] = (m_pend[e] && !clr) || rise;
        m_prev[e] = evt[e];
      end
      if (reg_wr) begin
        if (a == 0) m_gen = reg_wdata[0];
        else if (a == 1) begin
          if (int'(reg_wdata[3:0]) < m_lvl && m_stk.size() < 10) begin
            m_stk.push_back(m_lvl);
            m_lvl = int'(reg_wdata[3:0]);
          end
        end else if (a == 2) begin
          if (m_stk.size() > 0) m_lvl = m_stk.pop_back();
        end else if (a == 4 || a == 5) begin
          for (int k = 0; k < 32; k++) m_en[(a-4)*32+k] = reg_wdata[k];
        end else if (a >= 8 && a <= 15) begin
          for (int k = 0; k < 8; k++) m_map[(a-8)*8+k] = int'(reg_wdata[4*k +: 4]);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(chan_irq === m_irq, "R5 model irq", 64'(chan_irq), 64'(m_irq));
      chk(top_valid === m_tv && (!m_tv || top_evt === 6'(m_top)), "R6 model top",
          64'({top_valid, top_evt}), 64'({m_tv, 6'(m_top)}));
      chk(reg_rdata === model_read(int'(reg_addr)), "R3 model read",
          64'(reg_rdata), 64'(model_read(int'(reg_addr))));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    #2 d = reg_rdata;
  endtask

  task automatic pulse(input int e);
    @(negedge clk); evt[e] = 1'b1;
    @(negedge clk); evt[e] = 1'b0;
  endtask

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    step();
    // reset state
    chk(chan_irq == 10'd0, "R5 reset", 64'(chan_irq), 64'd0);
    rd(5'd0, d);  chk(d == 32'd0, "R7 reset", 64'(d), 64'd0);
    rd(5'd1, d);  chk(d == 32'd10, "R8 idle level", 64'(d), 64'd10);
    rd(5'd8, d);  chk(d == 32'hFFFF_FFFF, "R3 reset map", 64'(d), 64'hFFFF_FFFF);
    rd(5'd4, d);  chk(d == 32'd0, "R10 reset enable", 64'(d), 64'd0);

    wr(5'd4, 32'hFFFF_FFFF);
    wr(5'd5, 32'hFFFF_FFFF);
    wr(5'd0, 32'd1);
    wr(5'd8, 32'hFF3F_FFFF);           // event 5 -> channel 3
    @(negedge clk); evt[5] = 1'b1;
    step();
    chk(chan_irq == 10'd0, "R5 not before pending", 64'(chan_irq), 64'd0);
    step();
    chk(chan_irq == 10'h008, "R5 rise", 64'(chan_irq), 64'h008);
    chk(top_valid && top_evt == 6'd5, "R6 single", 64'(top_evt), 64'd5);

    wr(5'd6, 32'h20);                  // clear while level held high
    step();
    chk(chan_irq == 10'd0, "R2 clear drops irq", 64'(chan_irq), 64'd0);
    rd(5'd6, d); chk(d[5] == 1'b0, "R1 held level no re-set", 64'(d), 64'd0);
    @(negedge clk); evt[5] = 1'b0;

    // per-event enable
    wr(5'd13, 32'hFFFF_FFF1);          // event 40 -> channel 1
    wr(5'd5, 32'hFFFF_FEFF);           // event 40 disabled
    pulse(40);
    step(); step();
    rd(5'd7, d); chk(d[8] == 1'b1, "R10 pending while disabled", 64'(d[8]), 64'd1);
    chk(chan_irq == 10'd0, "R10 disabled silent", 64'(chan_irq), 64'd0);
    wr(5'd5, 32'hFFFF_FFFF);
    step();
    chk(chan_irq == 10'h002, "R10 enabled later", 64'(chan_irq), 64'h002);

    // unmapped values
    wr(5'd8, 32'hFC3F_FFFF);           // event 6 -> 12 (unmapped), event 7 stays 15
    pulse(6); pulse(7);
    step(); step();
    rd(5'd6, d); chk(d[7:6] == 2'b11, "R3 unmapped latch", 64'(d[7:6]), 64'd3);
    chk(chan_irq == 10'h002, "R3 unmapped silent", 64'(chan_irq), 64'h002);

    // remap
    pulse(5);
    step(); step();
    chk(chan_irq == 10'h00A, "R4 before remap", 64'(chan_irq), 64'h00A);
    wr(5'd8, 32'hFC7F_FFFF);           // event 5 -> channel 7
    step();
    chk(chan_irq == 10'h082, "R4 after remap", 64'(chan_irq), 64'h082);

    // priority
    chk(top_valid && top_evt == 6'd40, "R6 channel order", 64'(top_evt), 64'd40);
    wr(5'd8, 32'hFC7F_F7FF);           // event 2 -> channel 7
    pulse(2);
    wr(5'd7, 32'h100);                 // clear event 40
    step(); step();
    chk(chan_irq == 10'h080, "R6 ch7 only", 64'(chan_irq), 64'h080);
    chk(top_valid && top_evt == 6'd2, "R6 event order", 64'(top_evt), 64'd2);

    // same-cycle edge and clear
    @(negedge clk); evt[33] = 1'b1; reg_wr = 1'b1; reg_addr = 5'd7; reg_wdata = 32'h2;
    @(negedge clk); reg_wr = 1'b0; evt[33] = 1'b0;
    rd(5'd7, d); chk(d[1] == 1'b1, "R2 edge wins", 64'(d[1]), 64'd1);
    wr(5'd7, 32'h2);
    rd(5'd7, d); chk(d[1] == 1'b0, "R2 w1c", 64'(d[1]), 64'd0);

    // global gate
    wr(5'd0, 32'd0);
    step();
    chk(chan_irq == 10'd0, "R7 gated", 64'(chan_irq), 64'd0);
    pulse(40);
    step(); step();
    rd(5'd7, d); chk(d[8] == 1'b1, "R7 latch while gated", 64'(d[8]), 64'd1);
    chk(chan_irq == 10'd0, "R7 still gated", 64'(chan_irq), 64'd0);
    wr(5'd0, 32'd1);
    step();
    chk(chan_irq == 10'h082, "R7 ungated", 64'(chan_irq), 64'h082);

    // nesting
    wr(5'd1, 32'd7);
    step();
    chk(chan_irq == 10'h002, "R8 claim 7", 64'(chan_irq), 64'h002);
    wr(5'd1, 32'd9);
    rd(5'd1, d); chk(d == 32'd7, "R8 lower claim ignored", 64'(d), 64'd7);
    wr(5'd1, 32'd1);
    step();
    chk(chan_irq == 10'd0 && !top_valid, "R8 claim 1", 64'(chan_irq), 64'd0);
    wr(5'd2, 32'd0);
    step();
    chk(chan_irq == 10'h002, "R9 unwind to 7", 64'(chan_irq), 64'h002);
    wr(5'd2, 32'd0);
    step();
    chk(chan_irq == 10'h082, "R9 unwind to idle", 64'(chan_irq), 64'h082);
    wr(5'd2, 32'd0);
    rd(5'd1, d); chk(d == 32'd10, "R9 empty eoi ignored", 64'(d), 64'd10);
    step();
    finish_run();
  end

endmodule